// File: doc/BRIEF.md
# Receive-side pause frame detector

This block sits beside the byte-wide receive path of an Ethernet MAC and picks out flow-control pause frames. For each frame it checks three things as the bytes go past: the destination address, the length/type field and the control opcode. It also captures the 16-bit pause time. When the frame ends with a good CRC and flow control is enabled, it loads the pause time into a countdown. While the countdown is nonzero it holds off the start of any new transmission.

The countdown counts in pause quanta of 512 bit times. A tick input pulses once per quantum and steps the count down by one. Each accepted frame gives a one-cycle pulse. A newer accepted frame always replaces the count that is running, and a pause time of zero releases the hold-off at once. The transmit side reads `tx_inhibit` and starts no new frame while it is high. A frame it is already sending is not cut short.

Top module: `pause_rx_detect`

## Requirements
- R1: When `fc_enable` is 0 in the cycle of the closing byte, the frame is ignored. There is no pulse on `pause_seen` and the countdown is left as it was.
- R2: A destination address of 01-80-C2-00-00-01 is accepted. The first byte on the wire is 0x01. Any other address that is not the station address rejects the frame.
- R3: A destination address equal to `station_addr` is accepted. `station_addr[47:40]` is the first address byte on the wire and `station_addr[7:0]` is the sixth.
- R4: Bytes 12 and 13 of the frame must be 0x88 and 0x08, in that order, or the frame is rejected.
- R5: Bytes 14 and 15 must be 0x00 and 0x01, in that order, or the frame is rejected.
- R6: An accepted frame needs `rx_crc_ok` high with its closing byte and at least 18 bytes. Bytes 16 and 17 form the pause time, most significant byte first. `pause_seen` pulses for one cycle in the cycle after the closing byte, and the countdown holds the new value from that same cycle.
- R7: `tx_inhibit` is high exactly while the countdown is nonzero. Each `quanta_tick` lowers a nonzero count by one. After reset the count is 0, `tx_inhibit` is low and `pause_seen` is low.
- R8: An accepted frame overwrites any running count. A pause time of 0 drops `tx_inhibit` in the same cycle that `pause_seen` pulses.
- R9: A byte with `rx_sof` high starts a new frame and discards any frame that was partly parsed. Valid bytes that arrive outside a frame are ignored, including any `rx_eof` among them.
- R10: A load takes priority over a `quanta_tick` in the same cycle. The loaded value is kept as it is, and the first decrement comes on a later tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A receive byte is present this cycle |
| rx_sof | input | 1 | The present byte is the first byte of a frame |
| rx_eof | input | 1 | The present byte is the last byte of a frame |
| rx_data | input | 8 | Receive byte |
| rx_crc_ok | input | 1 | The frame is good; read together with the closing byte |
| station_addr | input | 48 | Station unicast address; bits 47:40 are the first byte on the wire |
| fc_enable | input | 1 | Enables receive flow control |
| quanta_tick | input | 1 | One pulse per pause quantum |
| tx_inhibit | output | 1 | High while the pause countdown is nonzero |
| pause_seen | output | 1 | One-cycle pulse when a pause frame is accepted |

## Verification
The assertions assume the frame markers arrive only on cycles where `rx_valid` is high. They also assume `station_addr` stays constant while a frame is being parsed. The bench keeps within both limits: it sets markers only inside its byte-driving task, and it sets the station address once before reset is released. Its stimulus covers the cases that stress these assumptions: markers on bytes that come outside any frame, a new start marker arriving in the middle of a frame, and ticks that fall in the same cycle as a closing byte.

// File: rtl/pfd_pkg.sv
// Package: constants shared by the pause frame detector.
// Byte offsets follow wire order; the parser depends on them.
package pfd_pkg;
    localparam int            MAC_BYTES   = 6;
    localparam logic [47:0]   PAUSE_MCAST = 48'h0180_C200_0001;
    localparam logic [15:0]   CTRL_TYPE   = 16'h8808;
    localparam logic [15:0]   PAUSE_OPC   = 16'h0001;
    localparam int            OFS_TYPE    = 12;
    localparam int            OFS_OPC     = 14;
    localparam int            OFS_PTIME   = 16;

    // Running verdict for the fields seen so far in a frame.
    typedef struct packed {
        logic mc_ok;
        logic uc_ok;
        logic type_ok;
        logic opc_ok;
    } field_ok_t;
endpackage

// File: rtl/pfd_byte_index.sv
// Module: tracks where the receive stream is inside a frame.
// It gives the position of the byte present this cycle, and flags
// bytes that belong to a frame and the byte that closes one.
// Assumes: rx_sof and rx_eof are only meaningful with rx_valid.
module pfd_byte_index #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    output logic [IDX_W-1:0] cur_idx,
    output logic             byte_live,
    output logic             frame_end
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic             in_frame_q;
    logic [IDX_W-1:0] idx_q;

    // Position of the present byte; a start marker forces zero.
    always_comb begin
        cur_idx   = rx_sof ? '0 : idx_q;
        byte_live = rx_valid && (rx_sof || in_frame_q);
        frame_end = byte_live && rx_eof;
    end

    // Advance the saturating position and the in-frame flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame_q <= 1'b0;
            idx_q      <= '0;
        end else if (byte_live) begin
            in_frame_q <= !rx_eof;
            idx_q      <= (cur_idx == IDX_MAX) ? IDX_MAX : cur_idx + 1'b1;
        end
    end
endmodule

// File: rtl/pfd_field_match.sv
// Module: compares the header fields of a frame byte by byte and
// captures the pause time. Its outputs already include the byte
// present this cycle, so the decision can be taken on the closing byte.
// Assumes: station_addr is stable while a frame is parsed.
module pfd_field_match
    import pfd_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int PT_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_live,
    input  logic             first_byte,
    input  logic [IDX_W-1:0] cur_idx,
    input  logic [7:0]       rx_data,
    input  logic [47:0]      station_addr,
    output logic             hdr_match,
    output logic [PT_W-1:0]  ptime_now
);
    localparam int PT_BYTES = PT_W / 8;
    localparam logic [IDX_W-1:0] I_TYPE0 = IDX_W'(OFS_TYPE);
    localparam logic [IDX_W-1:0] I_TYPE1 = IDX_W'(OFS_TYPE + 1);
    localparam logic [IDX_W-1:0] I_OPC0  = IDX_W'(OFS_OPC);
    localparam logic [IDX_W-1:0] I_OPC1  = IDX_W'(OFS_OPC + 1);
    localparam logic [IDX_W-1:0] I_PT_LO = IDX_W'(OFS_PTIME);
    localparam logic [IDX_W-1:0] I_PT_HI = IDX_W'(OFS_PTIME + PT_BYTES);

    field_ok_t           ok_q, ok_base, ok_n;
    logic [PT_W-1:0]     pt_q, pt_base, pt_n;
    logic [MAC_BYTES-1:0] da_sel, mc_eq, uc_eq;

    // One compare lane per destination address byte.
    for (genvar g = 0; g < MAC_BYTES; g++) begin : g_da_lane
        localparam int SH = 8 * (MAC_BYTES - 1 - g);
        assign da_sel[g] = (cur_idx == IDX_W'(g));
        assign mc_eq[g]  = (rx_data == PAUSE_MCAST[SH +: 8]);
        assign uc_eq[g]  = (rx_data == station_addr[SH +: 8]);
    end

    // Fold the present byte into the running verdict.
    always_comb begin
        ok_base = first_byte ? '{mc_ok: 1'b1, uc_ok: 1'b1, type_ok: 1'b1, opc_ok: 1'b1} : ok_q;
        pt_base = first_byte ? '0 : pt_q;
        ok_n    = ok_base;
        pt_n    = pt_base;
        if (|da_sel) begin
            ok_n.mc_ok = ok_base.mc_ok && !(|(da_sel & ~mc_eq));
            ok_n.uc_ok = ok_base.uc_ok && !(|(da_sel & ~uc_eq));
        end
        if (cur_idx == I_TYPE0) ok_n.type_ok = ok_base.type_ok && (rx_data == CTRL_TYPE[15:8]);
        if (cur_idx == I_TYPE1) ok_n.type_ok = ok_base.type_ok && (rx_data == CTRL_TYPE[7:0]);
        if (cur_idx == I_OPC0)  ok_n.opc_ok  = ok_base.opc_ok  && (rx_data == PAUSE_OPC[15:8]);
        if (cur_idx == I_OPC1)  ok_n.opc_ok  = ok_base.opc_ok  && (rx_data == PAUSE_OPC[7:0]);
        if (cur_idx >= I_PT_LO && cur_idx < I_PT_HI) pt_n = {pt_base[PT_W-9:0], rx_data};
    end

    // Verdict as of the present byte, for the frame decision.
    always_comb begin
        hdr_match = (ok_n.mc_ok || ok_n.uc_ok) && ok_n.type_ok && ok_n.opc_ok;
        ptime_now = pt_n;
    end

    // Keep the verdict for the next byte of the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q <= '0;
            pt_q <= '0;
        end else if (byte_live) begin
            ok_q <= ok_n;
            pt_q <= pt_n;
        end
    end
endmodule

// File: rtl/pfd_pause_timer.sv
// Module: pause countdown in quanta. A load replaces the count and
// wins over a tick in the same cycle. The hold-off follows count != 0.
module pfd_pause_timer #(
    parameter int PT_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PT_W-1:0] load_val,
    input  logic            tick,
    output logic            hold_off
);
    logic [PT_W-1:0] count_q;

    // Load, or step down on a tick until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                       count_q <= '0;
        else if (load)                    count_q <= load_val;
        else if (tick && count_q != '0)   count_q <= count_q - 1'b1;
    end

    // Transmit hold-off while any quanta remain.
    always_comb hold_off = (count_q != '0);
endmodule

// File: rtl/pause_rx_detect.sv
// Module: top level of the receive-side pause frame detector.
// It ties together position tracking, field compare and the countdown,
// and takes the accept decision on the closing byte of a frame.
// Assumes: markers come only with rx_valid, and rx_crc_ok is read only
// with the closing byte.
module pause_rx_detect
    import pfd_pkg::*;
#(
    parameter int IDX_W = 5,
    parameter int PT_W  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic [7:0]  rx_data,
    input  logic        rx_crc_ok,
    input  logic [47:0] station_addr,
    input  logic        fc_enable,
    input  logic        quanta_tick,
    output logic        tx_inhibit,
    output logic        pause_seen
);
    localparam int MIN_BYTES = OFS_PTIME + PT_W / 8;
    localparam logic [IDX_W-1:0] I_LAST_MIN = IDX_W'(MIN_BYTES - 1);

    logic [IDX_W-1:0] cur_idx;
    logic             byte_live, frame_end, hdr_match, accept;
    logic [PT_W-1:0]  ptime_now;

    pfd_byte_index #(.IDX_W(IDX_W)) u_idx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .cur_idx(cur_idx), .byte_live(byte_live),
        .frame_end(frame_end)
    );

    pfd_field_match #(.IDX_W(IDX_W), .PT_W(PT_W)) u_match (
        .clk(clk), .rst_n(rst_n), .byte_live(byte_live), .first_byte(rx_sof),
        .cur_idx(cur_idx), .rx_data(rx_data), .station_addr(station_addr),
        .hdr_match(hdr_match), .ptime_now(ptime_now)
    );

    // Accept on a good, long enough, enabled frame with matching fields.
    always_comb accept = frame_end && rx_crc_ok && fc_enable && hdr_match
                         && (cur_idx >= I_LAST_MIN);

    pfd_pause_timer #(.PT_W(PT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_val(ptime_now),
        .tick(quanta_tick), .hold_off(tx_inhibit)
    );

    // One-cycle pulse per accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n) pause_seen <= 1'b0;
        else        pause_seen <= accept;
    end
endmodule

// File: rtl/pfd_checker.sv
// Module: port-level properties of the pause frame detector, bound
// to the top module.
module pfd_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic rx_eof,
    input logic rx_crc_ok,
    input logic fc_enable,
    input logic quanta_tick,
    input logic tx_inhibit,
    input logic pause_seen
);
    p_pulse_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pause_seen |-> $past(fc_enable));

    p_pulse_needs_crc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pause_seen |-> $past(rx_crc_ok));

    p_pulse_needs_close_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pause_seen |-> $past(rx_valid && rx_eof));

    p_rise_needs_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_inhibit) |-> pause_seen);

    p_fall_needs_tick_or_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_inhibit) |-> ($past(quanta_tick) || pause_seen));

    p_pulse_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pause_seen |=> !pause_seen);
endmodule

bind pause_rx_detect pfd_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_eof(rx_eof),
    .rx_crc_ok(rx_crc_ok), .fc_enable(fc_enable), .quanta_tick(quanta_tick),
    .tx_inhibit(tx_inhibit), .pause_seen(pause_seen)
);

// File: tb/tb_pause_rx_detect.sv
module tb_pause_rx_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_crc_ok = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic [47:0] station_addr = 48'h0211_2233_4455;
    logic        fc_enable = 1'b1;
    logic        quanta_tick = 1'b0;
    logic        tx_inhibit, pause_seen;

    localparam logic [47:0] MCAST = 48'h0180_C200_0001;

    int total = 0, bad = 0, dut_pulses = 0, cyc = 0;
    bit tick_on = 1'b0;
    int tick_div = 4;
    bit done = 1'b0;
    string cur_req = "R7";

    // Reference model state
    byte unsigned q[$];
    bit  m_inframe = 1'b0;
    int  m_timer = 0;
    bit  m_pulse = 1'b0;

    always #5 clk = ~clk;

    pause_rx_detect dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .rx_crc_ok(rx_crc_ok),
        .station_addr(station_addr), .fc_enable(fc_enable),
        .quanta_tick(quanta_tick), .tx_inhibit(tx_inhibit), .pause_seen(pause_seen)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        bit good;
        good = 1'b0;
        if (!rst_n) begin
            q.delete(); m_inframe = 1'b0; m_timer = 0;
        end else begin
            if (rx_valid && (rx_sof || m_inframe)) begin
                if (rx_sof) q.delete();
                q.push_back(rx_data);
                m_inframe = !rx_eof;
                if (rx_eof && rx_crc_ok && fc_enable && q.size() >= 18) begin
                    bit da_mc, da_uc;
                    da_mc = 1'b1; da_uc = 1'b1;
                    for (int i = 0; i < 6; i++) begin
                        if (q[i] != MCAST[8*(5-i) +: 8]) da_mc = 1'b0;
                        if (q[i] != station_addr[8*(5-i) +: 8]) da_uc = 1'b0;
                    end
                    good = (da_mc || da_uc) && q[12] == 8'h88 && q[13] == 8'h08
                           && q[14] == 8'h00 && q[15] == 8'h01;
                end
            end
            if (good) m_timer = q[16] * 256 + q[17];
            else if (quanta_tick && m_timer > 0) m_timer = m_timer - 1;
        end
        m_pulse = good;
    end

    // Compare against the model away from the active edge
    always @(negedge clk) begin
        cyc++;
        quanta_tick <= tick_on && (cyc % tick_div == 0);
        if (rst_n) begin
            if (pause_seen) dut_pulses++;
            check(tx_inhibit === (m_timer != 0), {cur_req, " tx_inhibit"}, int'(tx_inhibit), int'(m_timer != 0));
            check(pause_seen === m_pulse, {cur_req, " pause_seen"}, int'(pause_seen), int'(m_pulse));
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [47:0] da, input logic [15:0] ty,
                              input logic [15:0] op, input logic [15:0] pt,
                              input int len, input bit crc, input bit with_sof,
                              input bit with_eof);
        for (int i = 0; i < len; i++) begin
            logic [7:0] v;
            if (i < 6)       v = da[8*(5-i) +: 8];
            else if (i < 12) v = 8'h30 + 8'(i);
            else if (i == 12) v = ty[15:8];
            else if (i == 13) v = ty[7:0];
            else if (i == 14) v = op[15:8];
            else if (i == 15) v = op[7:0];
            else if (i == 16) v = pt[15:8];
            else if (i == 17) v = pt[7:0];
            else v = 8'hA5 ^ 8'(i);
            @(negedge clk);
            rx_valid  = 1'b1;
            rx_sof    = with_sof && (i == 0);
            rx_eof    = with_eof && (i == len - 1);
            rx_crc_ok = crc && (i == len - 1);
            rx_data   = v;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_crc_ok = 1'b0;
    endtask

    task automatic frame_expect(input string req, input logic [47:0] da,
                                input logic [15:0] ty, input logic [15:0] op,
                                input logic [15:0] pt, input int len,
                                input bit crc, input int exp_pulses);
        int p0;
        cur_req = req;
        p0 = dut_pulses;
        send_frame(da, ty, op, pt, len, crc, 1'b1, 1'b1);
        idle(3);
        check(dut_pulses - p0 == exp_pulses, {req, " pulse count"}, dut_pulses - p0, exp_pulses);
    endtask

    task automatic wait_release(input string req, input int limit);
        int n;
        n = 0;
        while (tx_inhibit && n < limit) begin @(negedge clk); n++; end
        check(tx_inhibit == 1'b0, {req, " release"}, int'(tx_inhibit), 0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_inhibit == 1'b0, "R7 reset inhibit", int'(tx_inhibit), 0);
        check(pause_seen == 1'b0, "R7 reset pulse", int'(pause_seen), 0);

        tick_on = 1'b1; tick_div = 2;
        frame_expect("R2", MCAST, 16'h8808, 16'h0001, 16'd5, 64, 1'b1, 1);
        check(tx_inhibit == 1'b1, "R6 inhibit after load", int'(tx_inhibit), 1);
        wait_release("R7", 40);

        frame_expect("R3", 48'h0211_2233_4455, 16'h8808, 16'h0001, 16'd3, 60, 1'b1, 1);
        wait_release("R3", 40);
        frame_expect("R2", 48'h0211_2233_4456, 16'h8808, 16'h0001, 16'd3, 60, 1'b1, 0);
        frame_expect("R2", 48'h0180_C200_0002, 16'h8808, 16'h0001, 16'd3, 60, 1'b1, 0);
        frame_expect("R4", MCAST, 16'h8809, 16'h0001, 16'd3, 60, 1'b1, 0);
        frame_expect("R4", MCAST, 16'h0888, 16'h0001, 16'd3, 60, 1'b1, 0);
        frame_expect("R5", MCAST, 16'h8808, 16'h0002, 16'd3, 60, 1'b1, 0);
        frame_expect("R5", MCAST, 16'h8808, 16'h0100, 16'd3, 60, 1'b1, 0);
        frame_expect("R6", MCAST, 16'h8808, 16'h0001, 16'd3, 60, 1'b0, 0);
        frame_expect("R6", MCAST, 16'h8808, 16'h0001, 16'd3, 17, 1'b1, 0);
        frame_expect("R6", MCAST, 16'h8808, 16'h0001, 16'd2, 18, 1'b1, 1);
        wait_release("R6", 40);

        fc_enable = 1'b0;
        frame_expect("R1", MCAST, 16'h8808, 16'h0001, 16'd9, 60, 1'b1, 0);
        check(tx_inhibit == 1'b0, "R1 no hold-off", int'(tx_inhibit), 0);
        fc_enable = 1'b1;

        tick_on = 1'b0;
        frame_expect("R8", MCAST, 16'h8808, 16'h0001, 16'd200, 60, 1'b1, 1);
        frame_expect("R8", MCAST, 16'h8808, 16'h0001, 16'd0, 60, 1'b1, 1);
        check(tx_inhibit == 1'b0, "R8 zero releases", int'(tx_inhibit), 0);
        frame_expect("R8", MCAST, 16'h8808, 16'h0001, 16'd300, 60, 1'b1, 1);
        tick_on = 1'b1; tick_div = 1;
        frame_expect("R8", MCAST, 16'h8808, 16'h0001, 16'd3, 60, 1'b1, 1);
        wait_release("R8", 10);

        cur_req = "R9";
        begin
            int p0;
            p0 = dut_pulses;
            send_frame(MCAST, 16'h8808, 16'h0001, 16'd7, 60, 1'b1, 1'b0, 1'b1);
            idle(3);
            check(dut_pulses == p0, "R9 no start marker", dut_pulses - p0, 0);
            send_frame(48'h1234_5678_9ABC, 16'h0800, 16'h4500, 16'd0, 10, 1'b0, 1'b1, 1'b0);
            send_frame(MCAST, 16'h8808, 16'h0001, 16'd6, 30, 1'b1, 1'b1, 1'b1);
            idle(3);
            check(dut_pulses - p0 == 1, "R9 restart on start marker", dut_pulses - p0, 1);
        end
        wait_release("R9", 40);

        tick_on = 1'b1; tick_div = 1;
        frame_expect("R10", MCAST, 16'h8808, 16'h0001, 16'd4, 40, 1'b1, 1);
        wait_release("R10", 20);

        idle(5);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule